// File: doc/BRIEF.md
# Boot-Aware Remappable Address Decoder

This block turns a master's address into a one-hot slave select for a five-slave interconnect. Each master gets its own copy, and every copy uses the same address map. The address space is cut into 1 MB pages. The upper address bits, called the page number, pick the target. Any page that has no target raises a decode-error flag, and no slave is selected.

Page 0 is the boot window, and its target is not fixed. Out of reset it points at the on-chip ROM or at the external bus, as set by a boot-mode pin captured at reset. A one-cycle remap pulse then moves the window to SRAM bank 0 for good, so software can install its own exception vectors. The window stays on SRAM bank 0 until the next reset. The decode itself is combinational. The select is valid in the same cycle as the address, and only the boot choice and the remap flag are stored.

Top module: `boot_remap_decoder`

## Requirements
- R1: Page 0x001 selects the internal ROM (select bit 2) in every state.
- R2: Page 0x002 selects SRAM bank 0 (bit 0) and page 0x003 selects SRAM bank 1 (bit 1).
- R3: Pages 0x100 to 0x1FF inclusive select the external bus (bit 3).
- R4: Page 0xFFF selects the peripheral space (bit 4).
- R5: Any other page drives an all-zero select with the decode error high. A mapped page drives exactly one select bit with the decode error low.
- R6: Suppose boot mode was captured low and no remap has happened. Then page 0 selects the ROM (bit 2).
- R7: Suppose boot mode was captured high and no remap has happened. Then page 0 selects the external bus (bit 3).
- R8: The boot-mode pin is captured at the last rising clock edge that has reset (active low) asserted. Changes to the pin after that edge have no effect.
- R9: After a clock edge at which the remap input is high outside reset, page 0 selects SRAM bank 0 (bit 0), whatever the boot mode.
- R10: Once set, the remap state persists through further pulses and pin changes. Only reset clears it.
- R11: The outputs follow the address combinationally. A remap pulse does not change the decode in the cycle it is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| boot_mode_i | input | 1 | Boot source: 0 internal ROM, 1 external bus |
| remap_i | input | 1 | One-cycle request to move the boot window to SRAM bank 0 |
| addr_i | input | ADDR_W | Master address |
| slave_sel_o | output | 5 | One-hot select: 0 SRAM0, 1 SRAM1, 2 ROM, 3 external bus, 4 peripherals |
| dec_err_o | output | 1 | No slave mapped at this address |

## Verification
The bench builds the decoder with its default parameters. These are a 32-bit address, 1 MB pages, and the default page numbers. At these values the edges of the external-bus window and the neighbours of every mapped page can be reached with plain addresses. The bench walks all three boot-window targets across three resets, with the boot pin toggled both during reset and after it. A random address sweep then covers the unmapped pages that the directed steps do not reach.

// File: rtl/boot_remap_decoder.sv
module boot_remap_decoder #(
  parameter int ADDR_W    = 32,
  parameter int PAGE_W    = 20,
  parameter int ROM_PG    = 'h001,
  parameter int SRAM0_PG  = 'h002,
  parameter int SRAM1_PG  = 'h003,
  parameter int EBI_LO_PG = 'h100,
  parameter int EBI_HI_PG = 'h1FF,
  parameter int PERI_PG   = 'hFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              boot_mode_i,
  input  logic              remap_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [4:0]        slave_sel_o,
  output logic              dec_err_o
);
  localparam int PG_W = ADDR_W - PAGE_W;

  logic [PG_W-1:0] pg;
  logic boot_ext_q, remap_q;
  logic in_boot, in_rom, in_s0, in_s1, in_ebi, in_peri;
  logic unused_low;

  assign pg         = addr_i[ADDR_W-1:PAGE_W];
  assign unused_low = ^addr_i[PAGE_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      boot_ext_q <= boot_mode_i;
      remap_q    <= 1'b0;
    end else if (remap_i) begin
      remap_q    <= 1'b1;
    end
  end

  assign in_boot = (pg == '0);
  assign in_rom  = (pg == PG_W'(ROM_PG));
  assign in_s0   = (pg == PG_W'(SRAM0_PG));
  assign in_s1   = (pg == PG_W'(SRAM1_PG));
  assign in_ebi  = (pg >= PG_W'(EBI_LO_PG)) && (pg <= PG_W'(EBI_HI_PG));
  assign in_peri = (pg == PG_W'(PERI_PG));

  assign slave_sel_o[0] = in_s0 | (in_boot & remap_q);
  assign slave_sel_o[1] = in_s1;
  assign slave_sel_o[2] = in_rom | (in_boot & ~remap_q & ~boot_ext_q);
  assign slave_sel_o[3] = in_ebi | (in_boot & ~remap_q &  boot_ext_q);
  assign slave_sel_o[4] = in_peri;

  assign dec_err_o = ~(in_boot | in_rom | in_s0 | in_s1 | in_ebi | in_peri);
endmodule

// File: rtl/boot_remap_decoder_chk.sv
module boot_remap_decoder_chk #(
  parameter int ADDR_W  = 32,
  parameter int PAGE_W  = 20,
  parameter int ROM_PG  = 'h001
) (
  input logic              clk,
  input logic              rst_n,
  input logic              remap_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [4:0]        slave_sel_o,
  input logic              dec_err_o,
  input logic              boot_ext_q,
  input logic              remap_q
);
  localparam int PG_W = ADDR_W - PAGE_W;
  logic [PG_W-1:0] cpg;
  logic unused_chk;
  assign cpg        = addr_i[ADDR_W-1:PAGE_W];
  assign unused_chk = ^addr_i[PAGE_W-1:0];

  p_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(slave_sel_o) && ((slave_sel_o == 5'b0) == dec_err_o));

  p_rom_fixed_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cpg == PG_W'(ROM_PG)) |-> (slave_sel_o == 5'b00100));

  p_boot_int_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cpg == '0 && !remap_q && !boot_ext_q) |-> (slave_sel_o == 5'b00100));

  p_boot_ext_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cpg == '0 && !remap_q && boot_ext_q) |-> (slave_sel_o == 5'b01000));

  p_pin_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(boot_ext_q));

  p_remap_sram_r9: assert property (@(posedge clk) disable iff (!rst_n)
    remap_i |=> (cpg != '0 || slave_sel_o == 5'b00001));

  p_remap_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    remap_q |=> remap_q);
endmodule

bind boot_remap_decoder boot_remap_decoder_chk #(
  .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .ROM_PG(ROM_PG)
) u_chk (.*);

// File: tb/test_boot_remap_decoder.sv
module test_boot_remap_decoder;
  logic clk = 1'b0;
  logic rst_n = 1'b0, boot_mode = 1'b0, remap = 1'b0;
  logic [31:0] addr = '0;
  logic [4:0] sel;
  logic err;
  int checks = 0, errors = 0;
  bit m_boot = 1'b0, m_remap = 1'b0;

  always #5 clk = ~clk;

  boot_remap_decoder i_boot_remap_decoder (
    .clk(clk), .rst_n(rst_n), .boot_mode_i(boot_mode), .remap_i(remap),
    .addr_i(addr), .slave_sel_o(sel), .dec_err_o(err));

  always @(posedge clk) begin
    if (!rst_n) begin m_boot <= boot_mode; m_remap <= 1'b0; end
    else if (remap) m_remap <= 1'b1;
  end

  function automatic logic [4:0] ref_sel(input logic [31:0] a);
    int p = int'(a[31:20]);
    if (p == 0)                  return m_remap ? 5'b00001 : (m_boot ? 5'b01000 : 5'b00100);
    if (p == 1)                  return 5'b00100;
    if (p == 2)                  return 5'b00001;
    if (p == 3)                  return 5'b00010;
    if (p >= 'h100 && p <= 'h1FF) return 5'b01000;
    if (p == 'hFFF)              return 5'b10000;
    return 5'b00000;
  endfunction

  task automatic step(input logic [31:0] a, input logic rm, input logic pin,
                      input logic rn, input string req);
    logic [4:0] e;
    @(negedge clk);
    addr = a; remap = rm; boot_mode = pin; rst_n = rn;
    #1;
    if (rn) begin
      e = ref_sel(a);
      checks++;
      if (sel !== e || err !== (e == 5'b0)) begin
        errors++;
        $display("FAIL %s addr=%h actual sel=%b err=%b expected sel=%b err=%b",
                 req, a, sel, err, e, (e == 5'b0));
      end
    end
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // reset, pin low -> internal boot
    for (int i = 0; i < 3; i++) step(32'h0, 0, 0, 0, "reset");
    step(32'h0000_0000, 0, 0, 1, "R6");
    step(32'h000F_FFFC, 0, 0, 1, "R6");
    step(32'h0010_0000, 0, 0, 1, "R1");
    step(32'h0020_0000, 0, 0, 1, "R2");
    step(32'h0030_0010, 0, 0, 1, "R2");
    step(32'h1000_0000, 0, 0, 1, "R3");
    step(32'h1FFF_FFFF, 0, 0, 1, "R3");
    step(32'h0FFF_FFFF, 0, 0, 1, "R5");
    step(32'h2000_0000, 0, 0, 1, "R5");
    step(32'h0040_0000, 0, 0, 1, "R5");
    step(32'hFFF0_0000, 0, 0, 1, "R4");
    step(32'hFFEF_FFFF, 0, 0, 1, "R5");
    // pin change after reset ignored
    step(32'h0000_0000, 0, 1, 1, "R8");
    step(32'h0000_0100, 0, 1, 1, "R8");
    // remap pulse: same cycle unchanged, next cycle SRAM0
    step(32'h0000_0000, 1, 1, 1, "R11");
    step(32'h0000_0000, 0, 1, 1, "R9");
    step(32'h0010_0000, 0, 1, 1, "R1");
    step(32'h0000_0040, 1, 0, 1, "R10");
    step(32'h0000_0040, 0, 0, 1, "R10");
    // reset with pin high -> external boot, remap cleared
    for (int i = 0; i < 2; i++) step(32'h0, 0, 1, 0, "reset");
    step(32'h0000_0000, 0, 1, 1, "R7");
    step(32'h0000_0000, 0, 0, 1, "R8");
    step(32'h0000_0000, 0, 0, 1, "R10");
    step(32'h0000_0000, 1, 0, 1, "R11");
    step(32'h0000_0000, 0, 0, 1, "R9");
    // pin toggles during reset: last sampled value wins
    step(32'h0, 0, 1, 0, "reset");
    step(32'h0, 0, 0, 0, "reset");
    step(32'h0, 0, 1, 0, "reset");
    step(32'h0000_0000, 0, 1, 1, "R8");
    step(32'h0000_0000, 0, 0, 1, "R7");
    for (int i = 0; i < 300; i++)
      step($urandom, ($urandom % 50) == 0, $urandom % 2, 1, "R5");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule